// File: doc/BRIEF.md
# Video Memory DMA Sequencer

This block runs the two bulk-transfer sequences of a video display controller. In copy mode it moves bytes from one place in the 64 KB video RAM to another. It reads one byte at a source pointer, writes that byte at the destination pointer, and then advances both pointers. In external mode it fetches 16-bit words from a 24-bit external bus, one request at a time, and hands each word to the data-port write path. That path applies its own target decode and address stride.

The transfer count, the source and the destination come in as register values and are captured when a start is accepted. The destination step is an 8-bit value. When the last element has moved, the block raises a one-cycle completion strobe. On that same cycle it presents the values software expects to find afterwards: the exhausted count, and either the final external source or the final destination address.

Top module: `video_dma_engine`

## Requirements
- R1: A count input of 0 performs 65536 transfers. Any other count N performs exactly N transfers.
- R2: In copy mode (startExt = 0), each transfer drives a read at the source byte address. The returned byte arrives one cycle later on vramRdData. The next cycle writes that byte at the destination. The source then adds 1 and the destination adds stepIn, both modulo 2^16. The source starts at {srcMidIn, srcLoIn}.
- R3: In external mode (startExt = 1), the first word address is srcHiIn[6:0] on bits 23:17, srcMidIn on bits 16:9 and srcLoIn on bits 8:1. Bit 0 is 0.
- R4: Each later external request adds 2 to address bits 16:0, modulo 2^17. Bits 23:17 never change during the transfer.
- R5: Only one external read is outstanding at a time. Each response word appears exactly once on portWrData with a one-cycle portWrEn, before the next request is raised.
- R6: On the completion cycle wbValid is high and wbLen is 0. After an external transfer, wbSrcValid is high, wbSrcLo and wbSrcMid hold bits 8:1 and 16:9 of the final address, and wbSrcHi holds the final bits 23:17 under the original srcHiIn bit 7. After a copy, wbAddrValid is high and wbAddr holds the final destination.
- R7: done is high for exactly one cycle, and busy is low on the next cycle. A start request that arrives while busy is ignored: it does not change the mode, the count, the addresses or the number of transfers.
- R8: Out of reset and while idle, busy, done, vramRdEn, vramWrEn, extReqValid and portWrEn are all low.
- R9: Once raised, extReqValid and extReqAddr stay unchanged until extReqReady is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startValid | input | 1 | Start request, taken only when idle |
| startExt | input | 1 | 1 = external word transfer, 0 = video RAM copy |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion strobe |
| lenIn | input | 16 | Transfer count (0 means 65536) |
| srcLoIn | input | 8 | Source low byte register |
| srcMidIn | input | 8 | Source middle byte register |
| srcHiIn | input | 8 | Source high register (bits 6:0 used, bit 7 kept) |
| addrIn | input | 16 | Destination address register |
| stepIn | input | 8 | Destination step |
| vramRdEn | output | 1 | Video RAM read strobe |
| vramRdAddr | output | 16 | Video RAM read address |
| vramRdData | input | 8 | Read data, one cycle after vramRdEn |
| vramWrEn | output | 1 | Video RAM write strobe |
| vramWrAddr | output | 16 | Video RAM write address |
| vramWrData | output | 8 | Video RAM write data |
| extReqValid | output | 1 | External read request |
| extReqReady | input | 1 | External request accepted |
| extReqAddr | output | 24 | External byte address |
| extRspValid | input | 1 | External read data valid |
| extRspData | input | 16 | External read word |
| portWrEn | output | 1 | Data-port write strobe |
| portWrData | output | 16 | Data-port write word |
| wbValid | output | 1 | Count write-back strobe |
| wbLen | output | 16 | Count to write back |
| wbSrcValid | output | 1 | Source write-back strobe (external mode) |
| wbSrcLo | output | 8 | Final source low byte |
| wbSrcMid | output | 8 | Final source middle byte |
| wbSrcHi | output | 8 | Final source high register |
| wbAddrValid | output | 1 | Destination write-back strobe (copy mode) |
| wbAddr | output | 16 | Final destination address |

## Verification
The assertions rely on a few properties of the environment. The external side returns exactly one response for each accepted request, and never a response with no request outstanding. The video RAM returns data with a fixed latency of one cycle. Register inputs may change at any time, because they are sampled only at start. The bench keeps within these limits by modelling a single-slot responder with a pseudo-random ready signal and a latency of 1 to 4 cycles, and a video RAM whose content is a fixed function of the address. It also deliberately wiggles the start and register inputs in the middle of a transfer.

// File: rtl/video_dma_pkg.sv
package video_dma_pkg;
  localparam int REG_W   = 8;
  localparam int XADDR_W = 24;
  localparam int WIN_W   = 17;
  localparam int TOP_W   = XADDR_W - WIN_W;
  localparam int WORD_W  = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CP_RD, ST_CP_WR, ST_EX_REQ, ST_EX_WAIT, ST_EX_PUSH, ST_FIN
  } dmaState_t;

  typedef struct packed {
    logic load;
    logic advCopy;
    logic advExt;
    logic latchWord;
  } dmaStrobes_t;
endpackage

// File: rtl/video_dma_ctrl.sv
module video_dma_ctrl
  import video_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  input  logic        startExt,
  input  logic        lastXfer,
  input  logic        extReqReady,
  input  logic        extRspValid,
  output dmaStrobes_t stb,
  output logic        busy,
  output logic        done,
  output logic        vramRdEn,
  output logic        vramWrEn,
  output logic        extReqValid,
  output logic        portWrEn,
  output logic        wbValid,
  output logic        wbSrcValid,
  output logic        wbAddrValid
);
  dmaState_t state, stateNext;
  logic modeExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      modeExt <= 1'b0;
    end else begin
      state <= stateNext;
      if (stb.load) modeExt <= startExt;
    end
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    case (state)
      ST_IDLE: if (startValid) begin
        stb.load  = 1'b1;
        stateNext = startExt ? ST_EX_REQ : ST_CP_RD;
      end
      ST_CP_RD:  stateNext = ST_CP_WR;
      ST_CP_WR: begin
        stb.advCopy = 1'b1;
        stateNext   = lastXfer ? ST_FIN : ST_CP_RD;
      end
      ST_EX_REQ: if (extReqReady) stateNext = ST_EX_WAIT;
      ST_EX_WAIT: if (extRspValid) begin
        stb.latchWord = 1'b1;
        stateNext     = ST_EX_PUSH;
      end
      ST_EX_PUSH: begin
        stb.advExt = 1'b1;
        stateNext  = lastXfer ? ST_FIN : ST_EX_REQ;
      end
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy        = (state != ST_IDLE);
  assign done        = (state == ST_FIN);
  assign vramRdEn    = (state == ST_CP_RD);
  assign vramWrEn    = (state == ST_CP_WR);
  assign extReqValid = (state == ST_EX_REQ);
  assign portWrEn    = (state == ST_EX_PUSH);
  assign wbValid     = done;
  assign wbSrcValid  = done && modeExt;
  assign wbAddrValid = done && !modeExt;
endmodule

// File: rtl/video_dma_datapath.sv
module video_dma_datapath
  import video_dma_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int VADDR_W = 16,
  parameter int STEP_W  = 8
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  dmaStrobes_t          stb,
  input  logic [LEN_W-1:0]     lenIn,
  input  logic [REG_W-1:0]     srcLoIn,
  input  logic [REG_W-1:0]     srcMidIn,
  input  logic [REG_W-1:0]     srcHiIn,
  input  logic [VADDR_W-1:0]   addrIn,
  input  logic [STEP_W-1:0]    stepIn,
  input  logic [WORD_W-1:0]    extRspData,
  output logic                 lastXfer,
  output logic [VADDR_W-1:0]   vramRdAddr,
  output logic [VADDR_W-1:0]   vramWrAddr,
  output logic [XADDR_W-1:0]   extReqAddr,
  output logic [WORD_W-1:0]    portWrData,
  output logic [LEN_W-1:0]     wbLen,
  output logic [REG_W-1:0]     wbSrcLo,
  output logic [REG_W-1:0]     wbSrcMid,
  output logic [REG_W-1:0]     wbSrcHi,
  output logic [VADDR_W-1:0]   wbAddr
);
  localparam int CNT_W = LEN_W + 1;

  logic [CNT_W-1:0]   remain;
  logic [VADDR_W-1:0] cpSrc, dst;
  logic [WIN_W-1:0]   winLow;
  logic [TOP_W-1:0]   winTop;
  logic               keepBit;
  logic [WORD_W-1:0]  word;
  logic [VADDR_W-1:0] stepExt;

  assign stepExt = {{(VADDR_W-STEP_W){1'b0}}, stepIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain  <= '0;
      cpSrc   <= '0;
      dst     <= '0;
      winLow  <= '0;
      winTop  <= '0;
      keepBit <= 1'b0;
      word    <= '0;
    end else begin
      if (stb.load) begin
        remain  <= (lenIn == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, lenIn};
        cpSrc   <= {srcMidIn, srcLoIn};
        dst     <= addrIn;
        winLow  <= {srcMidIn, srcLoIn, 1'b0};
        winTop  <= srcHiIn[TOP_W-1:0];
        keepBit <= srcHiIn[REG_W-1];
      end else if (stb.advCopy) begin
        remain <= remain - CNT_W'(1);
        cpSrc  <= cpSrc + VADDR_W'(1);
        dst    <= dst + stepExt;
      end else if (stb.advExt) begin
        remain <= remain - CNT_W'(1);
        winLow <= winLow + WIN_W'(2);
      end
      if (stb.latchWord) word <= extRspData;
    end
  end

  assign lastXfer   = (remain == CNT_W'(1));
  assign vramRdAddr = cpSrc;
  assign vramWrAddr = dst;
  assign extReqAddr = {winTop, winLow};
  assign portWrData = word;
  assign wbLen      = remain[LEN_W-1:0];
  assign wbSrcLo    = winLow[8:1];
  assign wbSrcMid   = winLow[16:9];
  assign wbSrcHi    = {keepBit, winTop};
  assign wbAddr     = dst;
endmodule

// File: rtl/video_dma_engine.sv
module video_dma_engine
  import video_dma_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int VADDR_W = 16,
  parameter int STEP_W  = 8
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               startValid,
  input  logic               startExt,
  output logic               busy,
  output logic               done,
  input  logic [LEN_W-1:0]   lenIn,
  input  logic [7:0]         srcLoIn,
  input  logic [7:0]         srcMidIn,
  input  logic [7:0]         srcHiIn,
  input  logic [VADDR_W-1:0] addrIn,
  input  logic [STEP_W-1:0]  stepIn,
  output logic               vramRdEn,
  output logic [VADDR_W-1:0] vramRdAddr,
  input  logic [7:0]         vramRdData,
  output logic               vramWrEn,
  output logic [VADDR_W-1:0] vramWrAddr,
  output logic [7:0]         vramWrData,
  output logic               extReqValid,
  input  logic               extReqReady,
  output logic [23:0]        extReqAddr,
  input  logic               extRspValid,
  input  logic [15:0]        extRspData,
  output logic               portWrEn,
  output logic [15:0]        portWrData,
  output logic               wbValid,
  output logic [LEN_W-1:0]   wbLen,
  output logic               wbSrcValid,
  output logic [7:0]         wbSrcLo,
  output logic [7:0]         wbSrcMid,
  output logic [7:0]         wbSrcHi,
  output logic               wbAddrValid,
  output logic [VADDR_W-1:0] wbAddr
);
  dmaStrobes_t stb;
  logic lastXfer;

  video_dma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startExt(startExt),
    .lastXfer(lastXfer), .extReqReady(extReqReady), .extRspValid(extRspValid),
    .stb(stb), .busy(busy), .done(done), .vramRdEn(vramRdEn), .vramWrEn(vramWrEn),
    .extReqValid(extReqValid), .portWrEn(portWrEn), .wbValid(wbValid),
    .wbSrcValid(wbSrcValid), .wbAddrValid(wbAddrValid)
  );

  video_dma_datapath #(.LEN_W(LEN_W), .VADDR_W(VADDR_W), .STEP_W(STEP_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .lenIn(lenIn), .srcLoIn(srcLoIn),
    .srcMidIn(srcMidIn), .srcHiIn(srcHiIn), .addrIn(addrIn), .stepIn(stepIn),
    .extRspData(extRspData), .lastXfer(lastXfer), .vramRdAddr(vramRdAddr),
    .vramWrAddr(vramWrAddr), .extReqAddr(extReqAddr), .portWrData(portWrData),
    .wbLen(wbLen), .wbSrcLo(wbSrcLo), .wbSrcMid(wbSrcMid), .wbSrcHi(wbSrcHi),
    .wbAddr(wbAddr)
  );

  // Copy data goes straight from the one-cycle read return to the write port.
  assign vramWrData = vramRdData;
endmodule

// File: rtl/video_dma_checker.sv
module video_dma_checker #(
  parameter int LEN_W = 16
)(
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             done,
  input logic             vramRdEn,
  input logic             vramWrEn,
  input logic             extReqValid,
  input logic             extReqReady,
  input logic [23:0]      extReqAddr,
  input logic             portWrEn,
  input logic             wbValid,
  input logic [LEN_W-1:0] wbLen
);
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !vramRdEn && !vramWrEn && !extReqValid && !portWrEn && !done);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    extReqValid && !extReqReady |=> extReqValid && $stable(extReqAddr));

  assert_one_outstanding_R5: assert property (@(posedge clk) disable iff (!rstN)
    extReqValid && extReqReady |=> !extReqValid);

  assert_push_no_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    portWrEn |-> !extReqValid);

  assert_window_top_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(extReqAddr[23:17]));

  assert_len_exhausted_R6: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> wbLen == '0);

  assert_copy_pair_R2: assert property (@(posedge clk) disable iff (!rstN)
    vramRdEn |=> vramWrEn);
endmodule

bind video_dma_engine video_dma_checker #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .vramRdEn(vramRdEn),
  .vramWrEn(vramWrEn), .extReqValid(extReqValid), .extReqReady(extReqReady),
  .extReqAddr(extReqAddr), .portWrEn(portWrEn), .wbValid(wbValid), .wbLen(wbLen)
);

// File: tb/video_dma_engine_tb.sv
module video_dma_engine_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic        startValid = 1'b0, startExt = 1'b0;
  logic        busy, done;
  logic [15:0] lenIn = '0;
  logic [7:0]  srcLoIn = '0, srcMidIn = '0, srcHiIn = '0;
  logic [15:0] addrIn = '0;
  logic [7:0]  stepIn = '0;
  logic        vramRdEn, vramWrEn;
  logic [15:0] vramRdAddr, vramWrAddr;
  logic [7:0]  vramRdData, vramWrData;
  logic        extReqValid, extReqReady;
  logic [23:0] extReqAddr;
  logic        extRspValid;
  logic [15:0] extRspData;
  logic        portWrEn;
  logic [15:0] portWrData;
  logic        wbValid, wbSrcValid, wbAddrValid;
  logic [15:0] wbLen, wbAddr;
  logic [7:0]  wbSrcLo, wbSrcMid, wbSrcHi;

  video_dma_engine u_dut (.*);

  int checkCount = 0;
  int errCount = 0;

  function automatic logic [7:0] vramPattern(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  function automatic logic [15:0] extWord(input logic [23:0] a);
    return {a[16:9] ^ a[23:16], a[8:1] ^ 8'hC3};
  endfunction

  function automatic logic [23:0] nextExt(input logic [23:0] a);
    return {a[23:17], a[16:0] + 17'd2};
  endfunction

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checkCount++;
    if (!ok) begin
      errCount++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  // Video RAM model: fixed content, one-cycle read latency.
  always @(posedge clk) vramRdData <= vramPattern(vramRdAddr);

  // External responder: single slot, pseudo-random ready and latency.
  logic [7:0]  lfsr;
  logic        slotBusy;
  logic [1:0]  lat;
  logic [23:0] slotAddr;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr <= 8'hA5; slotBusy <= 1'b0; lat <= '0; slotAddr <= '0;
      extReqReady <= 1'b0; extRspValid <= 1'b0; extRspData <= '0;
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      extRspValid <= 1'b0;
      if (slotBusy) begin
        if (lat == 2'd0) begin
          extRspValid <= 1'b1;
          extRspData  <= extWord(slotAddr);
          slotBusy    <= 1'b0;
        end else lat <= lat - 2'd1;
      end else if (extReqValid && extReqReady) begin
        slotBusy <= 1'b1; slotAddr <= extReqAddr; lat <= lfsr[2:1];
      end
      extReqReady <= lfsr[0] | lfsr[3];
    end
  end

  // Monitor: tracks expected addresses and tallies mismatches.
  logic [15:0] mSrc, mDst;
  logic [23:0] mReq, mPush;
  int wrCount, reqCount, pushCount, monErr;
  always @(negedge clk) begin
    if (rstN) begin
      if (vramWrEn) begin
        if (vramWrAddr !== mDst || vramWrData !== vramPattern(mSrc)) begin
          monErr++;
          $display("copy mismatch at %0h/%0h got %0h/%0h", mDst, mSrc, vramWrAddr, vramWrData);
        end
        wrCount++; mSrc = mSrc + 16'd1; mDst = mDst + {8'd0, stepIn};
      end
      if (extReqValid && extReqReady) begin
        if (extReqAddr !== mReq) begin
          monErr++;
          $display("request mismatch got %0h want %0h", extReqAddr, mReq);
        end
        reqCount++; mReq = nextExt(mReq);
      end
      if (extReqValid && slotBusy) monErr++;
      if (portWrEn) begin
        if (portWrData !== extWord(mPush)) monErr++;
        pushCount++; mPush = nextExt(mPush);
      end
    end
  end

  task automatic runXfer(input bit ext, input logic [15:0] len, input logic [7:0] lo,
                         input logic [7:0] mid, input logic [7:0] hi, input logic [15:0] dst,
                         input logic [7:0] step, input bit poke);
    int n;
    logic [16:0] fin;
    logic [15:0] expAddr;
    n = (len == 16'd0) ? 65536 : int'(len);
    @(negedge clk);
    wrCount = 0; reqCount = 0; pushCount = 0; monErr = 0;
    mSrc = {mid, lo}; mDst = dst;
    mReq = {hi[6:0], mid, lo, 1'b0}; mPush = mReq;
    lenIn = len; srcLoIn = lo; srcMidIn = mid; srcHiIn = hi; addrIn = dst; stepIn = step;
    startExt = ext; startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    chk(busy === 1'b1, "R7 busy after start", busy, 1);
    if (poke) begin
      // R7: start while busy with different mode and registers must be ignored.
      @(negedge clk);
      startValid = 1'b1; startExt = !ext; lenIn = 16'd2; srcLoIn = 8'h11;
      srcMidIn = 8'h22; srcHiIn = 8'h7F; addrIn = 16'h1234;
      @(negedge clk); @(negedge clk);
      startValid = 1'b0;
    end
    while (done !== 1'b1) @(negedge clk);
    fin = 17'({mid, lo, 1'b0} + 17'(2 * n));
    expAddr = 16'(dst + 16'(n * int'(step)));
    chk(wbValid === 1'b1 && wbLen === 16'd0, "R6 count write-back", wbLen, 0);
    chk(monErr == 0, "R2 R3 R4 R5 per-element mismatches", monErr, 0);
    if (ext) begin
      chk(reqCount == n && pushCount == n, "R1 R5 external transfer count", pushCount, n);
      chk(wbSrcValid === 1'b1 && wbAddrValid === 1'b0, "R6 source strobe", wbSrcValid, 1);
      chk(wbSrcLo === fin[8:1], "R6 R4 final source low", wbSrcLo, fin[8:1]);
      chk(wbSrcMid === fin[16:9], "R6 R4 final source mid", wbSrcMid, fin[16:9]);
      chk(wbSrcHi === hi, "R6 R4 final source high with kept bit", wbSrcHi, hi);
      chk(wrCount == 0, "R5 no video RAM writes in external mode", wrCount, 0);
    end else begin
      chk(wrCount == n, "R1 R2 copy transfer count", wrCount, n);
      chk(wbAddrValid === 1'b1 && wbSrcValid === 1'b0, "R6 address strobe", wbAddrValid, 1);
      chk(wbAddr === expAddr, "R6 R2 final destination", wbAddr, expAddr);
      chk(pushCount == 0 && reqCount == 0, "R2 no external traffic in copy", pushCount, 0);
    end
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R7 done one cycle then idle", {done, busy}, 0);
    repeat (4) @(negedge clk);
    chk(wrCount + pushCount == n && busy === 1'b0, "R7 no extra transfer after done",
        wrCount + pushCount, n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errCount++;
    $display("FAIL R7 watchdog expired: actual running expected finished");
    $display("  Simulation finished: %0d checks, %0d errors", checkCount, errCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, vramRdEn, vramWrEn, extReqValid, portWrEn} === 6'b0,
        "R8 reset outputs quiet", {busy, done, vramRdEn, vramWrEn, extReqValid, portWrEn}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy === 1'b0 && extReqValid === 1'b0, "R8 idle after reset", busy, 0);

    // R2 copy with source and destination wrapping, plus mid-run start (R7).
    runXfer(1'b0, 16'd5, 8'hFE, 8'hFF, 8'h00, 16'hFFF0, 8'd7, 1'b1);
    runXfer(1'b0, 16'd3, 8'h40, 8'h12, 8'h00, 16'h0100, 8'd0, 1'b0);
    runXfer(1'b0, 16'd1, 8'h00, 8'h80, 8'h00, 16'hFFFF, 8'd255, 1'b0);
    for (int l = 1; l <= 6; l++) begin
      for (int s = 0; s < 3; s++) begin
        logic [7:0] st;
        st = (s == 0) ? 8'd1 : (s == 1) ? 8'd2 : 8'd255;
        runXfer(1'b0, 16'(l), 8'(l * 17), 8'(l * 51), 8'h00, 16'(l * 4660), st, 1'b0);
      end
    end

    // R3 R4 external across the 128 KB window edge, kept bit set, mid-run start (R7).
    runXfer(1'b1, 16'd5, 8'hFE, 8'hFF, 8'hAA, 16'h0000, 8'd2, 1'b1);
    runXfer(1'b1, 16'd1, 8'h34, 8'h12, 8'h05, 16'h0000, 8'd2, 1'b0);
    for (int l = 1; l <= 4; l++) begin
      runXfer(1'b1, 16'(l), 8'(8'hFF - l), 8'hFF, 8'(l * 37), 16'h0000, 8'd1, 1'b0);
    end

    // R1 count of zero means 65536 copies.
    runXfer(1'b0, 16'd0, 8'h00, 8'h00, 8'h00, 16'h2000, 8'd1, 1'b0);

    $display("  Simulation finished: %0d checks, %0d errors", checkCount, errCount);
    $finish;
  end
endmodule